// File: doc/BRIEF.md
# RC4 Sliding-Window Key Search Engine

This block searches a captured byte buffer for a 128-bit RC4 key hidden somewhere inside it. Each 16-byte run of consecutive buffer bytes is treated as a candidate key. The candidate offsets advance one byte at a time. For every candidate the engine rebuilds the RC4 state table and generates keystream. It XORs that keystream with a stored ciphertext segment. It then grades the resulting plaintext.

Each candidate is graded in two ways. The first is the number of distinct byte values in the plaintext: genuine plaintext tends to use few of them, while a wrong key gives near-random bytes. The second is an optional test that a 32-bit marker sits at a chosen plaintext offset. The marker test only shows that the decryption is not garbage. It proves nothing about the origin of the data.

A host fills the capture and ciphertext buffers through two byte-wide write ports. It sets the configuration and pulses start. When done pulses, the host reads the winning offset, its score and its marker flag. Each candidate takes a fixed number of cycles, so the run time follows directly from the configuration.

Top module: `rc4_window_search`

## Requirements
- R1: After reset, busy, done, best_offset, best_score and best_magic are all 0.
- R2: The plaintext byte n (0 <= n < cfg_dec_len) equals ct[n] XOR z[n]. Here z is the standard RC4 keystream for the key whose byte k is cap[w+k], k = 0..15. The S-box starts as the identity and goes through 256 scheduling swaps with j += S[i] + key[i mod 16]. After that, each output step does i += 1, j += S[i], swaps S[i] and S[j], and emits S[S[i]+S[j]].
- R3: Every window offset from 0 to cfg_cap_len-16 is examined exactly once, in ascending order. best_offset reports the winning offset, so a key planted at offset w is reported as w.
- R4: The score of a window is the count of distinct byte values among its cfg_dec_len plaintext bytes, and best_score reports the winner's score.
- R5: The marker hits when cfg_magic_en is 1, cfg_magic_off+3 < cfg_dec_len, and plaintext bytes cfg_magic_off..cfg_magic_off+3 equal cfg_magic, with the byte at cfg_magic_off compared to bits 31:24 and the following bytes compared to successively lower bytes. Otherwise it misses. best_magic reports the winner's marker result.
- R6: A window whose marker hits beats any window whose marker misses. Between windows with the same marker result, the lower score wins. On a full tie, the earlier offset is kept.
- R7: busy is high from the cycle after the clock edge that accepts start until done. done is a one-cycle pulse with busy low, and it appears in the cycle that follows the edge W*(769+2*cfg_dec_len) edges after the accepting edge, where W is the number of windows.
- R8: If cfg_cap_len < 16, there are no windows (W = 0). done then pulses in the cycle right after the accepting edge, and all three results are 0.
- R9: A start pulse while busy has no effect on the run or its timing. The results hold their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_we | input | 1 | Capture buffer write enable |
| cap_addr | input | $clog2(CAP_DEPTH) | Capture buffer write address |
| cap_wdata | input | 8 | Capture buffer write byte |
| ct_we | input | 1 | Ciphertext buffer write enable |
| ct_addr | input | $clog2(CT_DEPTH) | Ciphertext buffer write address |
| ct_wdata | input | 8 | Ciphertext buffer write byte |
| cfg_cap_len | input | $clog2(CAP_DEPTH+1) | Number of valid capture bytes |
| cfg_dec_len | input | $clog2(CT_DEPTH+1) | Plaintext bytes scored per window |
| cfg_magic_off | input | $clog2(CT_DEPTH) | Plaintext offset of the marker |
| cfg_magic | input | 32 | Expected marker word |
| cfg_magic_en | input | 1 | Enables the marker test |
| start | input | 1 | Starts a search when idle |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| best_offset | output | $clog2(CAP_DEPTH) | Offset of the winning window |
| best_score | output | $clog2(CT_DEPTH+1) | Distinct-value count of the winner |
| best_magic | output | 1 | Marker result of the winner |

## Verification
All results are due together, in the cycle in which done rises. That cycle follows the start edge by exactly W*(769+2*cfg_dec_len) edges, or directly for an empty buffer. Before each start, the driver computes this count together with the expected winner from a plain software RC4 model, and queues both. The monitor samples on falling edges. When it sees done, it compares the elapsed edge count with the queued value, and it checks on the next falling edge that done has dropped. Holding and stray-start behaviour is checked a few cycles after done and during a run.

// File: rtl/rc4ws_pkg.sv
package rc4ws_pkg;
    localparam int KEY_BYTES = 16;
    localparam int SBOX_SIZE = 256;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_KSA_A,
        PH_KSA_B,
        PH_GEN_A,
        PH_GEN_B,
        PH_EVAL,
        PH_FIN
    } phase_e;
endpackage

// File: rtl/rc4ws_bytemem.sv
module rc4ws_bytemem #(
    parameter int DEPTH = 256,
    parameter int NRD   = 1
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [$clog2(DEPTH)-1:0]       waddr,
    input  logic [7:0]                     wdata,
    input  logic [NRD*$clog2(DEPTH)-1:0]   raddr,
    output logic [NRD*8-1:0]               rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g*8 +: 8] = mem_q[raddr[g*AW +: AW]];
    end
endmodule

// File: rtl/rc4ws_scorer.sv
module rc4ws_scorer #(
    parameter int CT_DEPTH = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            pt_valid,
    input  logic [7:0]                      pt_byte,
    input  logic [$clog2(CT_DEPTH+1)-1:0]   pt_idx,
    input  logic [$clog2(CT_DEPTH)-1:0]     moff,
    input  logic [31:0]                     mval,
    input  logic                            men,
    output logic [$clog2(CT_DEPTH+1)-1:0]   score,
    output logic                            hit
);
    localparam int CT_AW = $clog2(CT_DEPTH);
    localparam int CT_LW = $clog2(CT_DEPTH + 1);
    localparam int DW    = CT_LW + 1;

    typedef struct packed {
        logic [255:0]     seen;
        logic [CT_LW-1:0] score;
        logic [2:0]       mcnt;
        logic             mok;
    } sc_t;

    sc_t r_q, r_d;

    logic [DW-1:0] idx_x, off_x, diff_c;
    logic          in_win_c;
    logic [7:0]    exp_c;

    always_comb begin
        r_d      = r_q;
        idx_x    = DW'(pt_idx);
        off_x    = DW'(moff);
        diff_c   = idx_x - off_x;
        in_win_c = (idx_x >= off_x) && (diff_c < DW'(4));
        case (diff_c[1:0])
            2'd0:    exp_c = mval[31:24];
            2'd1:    exp_c = mval[23:16];
            2'd2:    exp_c = mval[15:8];
            default: exp_c = mval[7:0];
        endcase
        if (clear) begin
            r_d.seen  = '0;
            r_d.score = '0;
            r_d.mcnt  = '0;
            r_d.mok   = 1'b1;
        end else if (pt_valid) begin
            if (!r_q.seen[pt_byte]) begin
                r_d.seen[pt_byte] = 1'b1;
                r_d.score         = r_q.score + 1'b1;
            end
            if (in_win_c) begin
                r_d.mcnt = r_q.mcnt + 3'd1;
                if (pt_byte != exp_c) begin
                    r_d.mok = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign score = r_q.score;
    assign hit   = men && r_q.mok && (r_q.mcnt == 3'd4);

    assert_score_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !pt_valid) |=> $stable(r_q.score));

    assert_score_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && pt_valid) |=> (r_q.score == $past(r_q.score)) ||
                                 (r_q.score == $past(r_q.score) + 1'b1));

    assert_magic_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.mcnt <= 3'd4);
endmodule

// File: rtl/rc4_window_search.sv
module rc4_window_search #(
    parameter int CAP_DEPTH = 64,
    parameter int CT_DEPTH  = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cap_we,
    input  logic [$clog2(CAP_DEPTH)-1:0]     cap_addr,
    input  logic [7:0]                       cap_wdata,
    input  logic                             ct_we,
    input  logic [$clog2(CT_DEPTH)-1:0]      ct_addr,
    input  logic [7:0]                       ct_wdata,
    input  logic [$clog2(CAP_DEPTH+1)-1:0]   cfg_cap_len,
    input  logic [$clog2(CT_DEPTH+1)-1:0]    cfg_dec_len,
    input  logic [$clog2(CT_DEPTH)-1:0]      cfg_magic_off,
    input  logic [31:0]                      cfg_magic,
    input  logic                             cfg_magic_en,
    input  logic                             start,
    output logic                             busy,
    output logic                             done,
    output logic [$clog2(CAP_DEPTH)-1:0]     best_offset,
    output logic [$clog2(CT_DEPTH+1)-1:0]    best_score,
    output logic                             best_magic
);
    import rc4ws_pkg::*;

    localparam int CAP_AW = $clog2(CAP_DEPTH);
    localparam int CAP_LW = $clog2(CAP_DEPTH + 1);
    localparam int CT_AW  = $clog2(CT_DEPTH);
    localparam int CT_LW  = $clog2(CT_DEPTH + 1);

    typedef struct packed {
        phase_e            ph;
        logic [7:0]        cnt;
        logic [7:0]        i;
        logic [7:0]        j;
        logic [7:0]        si;
        logic [7:0]        sj;
        logic [7:0]        jn;
        logic [CT_LW-1:0]  pidx;
        logic [CAP_AW-1:0] win;
        logic [CAP_AW-1:0] last_win;
        logic [CT_LW-1:0]  dec_len;
        logic [CT_AW-1:0]  moff;
        logic [31:0]       mval;
        logic              men;
        logic              best_vld;
        logic [CAP_AW-1:0] best_off;
        logic [CT_LW-1:0]  best_sc;
        logic              best_hit;
    } ctl_t;

    ctl_t r_q, r_d;

    logic       sb_we;
    logic [7:0] sb_waddr, sb_wdata, sb_ra0, sb_ra1, sb_rd0, sb_rd1;
    logic [7:0] cap_rd, ct_rd;
    logic [CAP_AW-1:0] cap_ra;
    logic       sc_clear, pt_valid, sc_hit;
    logic [7:0] pt_byte;
    logic [CT_LW-1:0] sc_score;
    logic [7:0] i1_c, jn_c, t_c, ks_c;
    logic       better_c;

    rc4ws_bytemem #(.DEPTH(SBOX_SIZE), .NRD(2)) u_sbox (
        .clk   (clk),
        .we    (sb_we),
        .waddr (sb_waddr),
        .wdata (sb_wdata),
        .raddr ({sb_ra1, sb_ra0}),
        .rdata ({sb_rd1, sb_rd0})
    );

    rc4ws_bytemem #(.DEPTH(CAP_DEPTH), .NRD(1)) u_cap (
        .clk   (clk),
        .we    (cap_we),
        .waddr (cap_addr),
        .wdata (cap_wdata),
        .raddr (cap_ra),
        .rdata (cap_rd)
    );

    rc4ws_bytemem #(.DEPTH(CT_DEPTH), .NRD(1)) u_ct (
        .clk   (clk),
        .we    (ct_we),
        .waddr (ct_addr),
        .wdata (ct_wdata),
        .raddr (r_q.pidx[CT_AW-1:0]),
        .rdata (ct_rd)
    );

    rc4ws_scorer #(.CT_DEPTH(CT_DEPTH)) u_scorer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sc_clear),
        .pt_valid (pt_valid),
        .pt_byte  (pt_byte),
        .pt_idx   (r_q.pidx),
        .moff     (r_q.moff),
        .mval     (r_q.mval),
        .men      (r_q.men),
        .score    (sc_score),
        .hit      (sc_hit)
    );

    assign cap_ra = r_q.win + CAP_AW'(r_q.cnt[3:0]);

    always_comb begin
        r_d      = r_q;
        sb_we    = 1'b0;
        sb_waddr = '0;
        sb_wdata = '0;
        sb_ra0   = '0;
        sb_ra1   = '0;
        sc_clear = 1'b0;
        pt_valid = 1'b0;
        pt_byte  = '0;
        i1_c     = r_q.i + 8'd1;
        jn_c     = '0;
        t_c      = r_q.si + r_q.sj;
        ks_c     = '0;
        better_c = !r_q.best_vld ||
                   (sc_hit && !r_q.best_hit) ||
                   ((sc_hit == r_q.best_hit) && (sc_score < r_q.best_sc));
        case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.dec_len  = cfg_dec_len;
                    r_d.moff     = cfg_magic_off;
                    r_d.mval     = cfg_magic;
                    r_d.men      = cfg_magic_en;
                    r_d.last_win = CAP_AW'(cfg_cap_len - CAP_LW'(KEY_BYTES));
                    r_d.win      = '0;
                    r_d.cnt      = '0;
                    r_d.best_vld = 1'b0;
                    r_d.best_off = '0;
                    r_d.best_sc  = '0;
                    r_d.best_hit = 1'b0;
                    r_d.ph = (cfg_cap_len < CAP_LW'(KEY_BYTES)) ? PH_FIN : PH_INIT;
                end
            end
            PH_INIT: begin
                sc_clear = 1'b1;
                sb_we    = 1'b1;
                sb_waddr = r_q.cnt;
                sb_wdata = r_q.cnt;
                r_d.cnt  = r_q.cnt + 8'd1;
                r_d.j    = '0;
                if (r_q.cnt == 8'hFF) begin
                    r_d.ph = PH_KSA_A;
                end
            end
            PH_KSA_A: begin
                sb_ra0   = r_q.cnt;
                jn_c     = r_q.j + sb_rd0 + cap_rd;
                sb_ra1   = jn_c;
                sb_we    = 1'b1;
                sb_waddr = r_q.cnt;
                sb_wdata = sb_rd1;
                r_d.si   = sb_rd0;
                r_d.jn   = jn_c;
                r_d.ph   = PH_KSA_B;
            end
            PH_KSA_B: begin
                sb_we    = 1'b1;
                sb_waddr = r_q.jn;
                sb_wdata = r_q.si;
                r_d.j    = r_q.jn;
                r_d.cnt  = r_q.cnt + 8'd1;
                if (r_q.cnt == 8'hFF) begin
                    r_d.i    = '0;
                    r_d.j    = '0;
                    r_d.pidx = '0;
                    r_d.ph   = (r_q.dec_len == '0) ? PH_EVAL : PH_GEN_A;
                end else begin
                    r_d.ph = PH_KSA_A;
                end
            end
            PH_GEN_A: begin
                sb_ra0   = i1_c;
                jn_c     = r_q.j + sb_rd0;
                sb_ra1   = jn_c;
                sb_we    = 1'b1;
                sb_waddr = i1_c;
                sb_wdata = sb_rd1;
                r_d.i    = i1_c;
                r_d.si   = sb_rd0;
                r_d.sj   = sb_rd1;
                r_d.jn   = jn_c;
                r_d.ph   = PH_GEN_B;
            end
            PH_GEN_B: begin
                sb_we    = 1'b1;
                sb_waddr = r_q.jn;
                sb_wdata = r_q.si;
                sb_ra0   = t_c;
                ks_c     = (t_c == r_q.jn) ? r_q.si : sb_rd0;
                pt_valid = 1'b1;
                pt_byte  = ks_c ^ ct_rd;
                r_d.j    = r_q.jn;
                r_d.pidx = r_q.pidx + 1'b1;
                r_d.ph   = ((r_q.pidx + 1'b1) == r_q.dec_len) ? PH_EVAL : PH_GEN_A;
            end
            PH_EVAL: begin
                if (better_c) begin
                    r_d.best_vld = 1'b1;
                    r_d.best_off = r_q.win;
                    r_d.best_sc  = sc_score;
                    r_d.best_hit = sc_hit;
                end
                if (r_q.win == r_q.last_win) begin
                    r_d.ph = PH_FIN;
                end else begin
                    r_d.win = r_q.win + 1'b1;
                    r_d.cnt = '0;
                    r_d.ph  = PH_INIT;
                end
            end
            default: begin
                r_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.ph != PH_IDLE) && (r_q.ph != PH_FIN);
    assign done        = (r_q.ph == PH_FIN);
    assign best_offset = r_q.best_off;
    assign best_score  = r_q.best_sc;
    assign best_magic  = r_q.best_hit;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_IDLE && !start) |=>
            ($stable(best_offset) && $stable(best_score) && $stable(best_magic)));

    assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.best_vld) |-> (best_offset <= r_q.last_win));

    assert_window_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_EVAL && r_q.win != r_q.last_win) |=> (r_q.win == $past(r_q.win) + 1'b1));
endmodule

// File: tb/rc4_window_search_bench.sv
`timescale 1ns/1ps
module rc4_window_search_bench;
    localparam int CAP_DEPTH = 64;
    localparam int CT_DEPTH  = 32;
    localparam int PER       = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_we = 1'b0;
    logic [5:0]  cap_addr = '0;
    logic [7:0]  cap_wdata = '0;
    logic        ct_we = 1'b0;
    logic [4:0]  ct_addr = '0;
    logic [7:0]  ct_wdata = '0;
    logic [6:0]  cfg_cap_len = '0;
    logic [5:0]  cfg_dec_len = '0;
    logic [4:0]  cfg_magic_off = '0;
    logic [31:0] cfg_magic = '0;
    logic        cfg_magic_en = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, best_magic;
    logic [5:0]  best_offset;
    logic [5:0]  best_score;

    rc4_window_search #(.CAP_DEPTH(CAP_DEPTH), .CT_DEPTH(CT_DEPTH)) u_rc4_window_search (
        .clk(clk), .rst_n(rst_n),
        .cap_we(cap_we), .cap_addr(cap_addr), .cap_wdata(cap_wdata),
        .ct_we(ct_we), .ct_addr(ct_addr), .ct_wdata(ct_wdata),
        .cfg_cap_len(cfg_cap_len), .cfg_dec_len(cfg_dec_len),
        .cfg_magic_off(cfg_magic_off), .cfg_magic(cfg_magic), .cfg_magic_en(cfg_magic_en),
        .start(start), .busy(busy), .done(done),
        .best_offset(best_offset), .best_score(best_score), .best_magic(best_magic)
    );

    always #(PER/2) clk = ~clk;

    typedef struct packed {
        int off;
        int score;
        int hit;
        int cycles;
    } exp_t;

    exp_t   sbq[$];
    exp_t   last_e;
    int     pending = 0;
    longint t_start = 0;
    int     n_chk = 0;
    int     n_bad = 0;
    int     cap_m [CAP_DEPTH];
    int     ct_m  [CT_DEPTH];
    int     s_m   [256];
    int     ks_m  [CT_DEPTH];
    int     pt_m  [CT_DEPTH];
    int     lcg = 32'h1357_9bdf;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd8();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 16) & 255;
    endfunction

    task automatic wr_cap(input int a, input int v);
        cap_m[a] = v & 255;
        cap_we = 1'b1; cap_addr = 6'(a); cap_wdata = 8'(v);
        @(negedge clk);
        cap_we = 1'b0;
    endtask

    task automatic wr_ct(input int a, input int v);
        ct_m[a] = v & 255;
        ct_we = 1'b1; ct_addr = 5'(a); ct_wdata = 8'(v);
        @(negedge clk);
        ct_we = 1'b0;
    endtask

    // Plain RC4 from the requirement text (R2)
    task automatic model_ks(input int w, input int n);
        int j, t, a;
        for (int k = 0; k < 256; k++) s_m[k] = k;
        j = 0;
        for (int k = 0; k < 256; k++) begin
            j = (j + s_m[k] + cap_m[w + (k % 16)]) % 256;
            t = s_m[k]; s_m[k] = s_m[j]; s_m[j] = t;
        end
        a = 0; j = 0;
        for (int k = 0; k < n; k++) begin
            a = (a + 1) % 256;
            j = (j + s_m[a]) % 256;
            t = s_m[a]; s_m[a] = s_m[j]; s_m[j] = t;
            ks_m[k] = s_m[(s_m[a] + s_m[j]) % 256];
        end
    endtask

    task automatic model_eval(input int w, input int n, input int moff, input logic [31:0] mval,
                              input bit men, output int sc, output int hit);
        bit [255:0] seen;
        bit ok;
        int p;
        model_ks(w, n);
        seen = '0; sc = 0; ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            p = (ks_m[k] ^ ct_m[k]) & 255;
            if (!seen[p]) begin seen[p] = 1'b1; sc++; end
            if (k >= moff && k < moff + 4)
                if (p != ((mval >> (8 * (3 - (k - moff)))) & 255)) ok = 1'b0;
        end
        hit = (men && (moff + 4 <= n) && ok) ? 1 : 0;
    endtask

    task automatic plant(input int p, input int n);
        model_ks(p, n);
        for (int k = 0; k < n; k++) wr_ct(k, pt_m[k] ^ ks_m[k]);
    endtask

    task automatic run(input int cap_len, input int n, input int moff, input logic [31:0] mval,
                       input bit men, input bit stray_start);
        exp_t e;
        int nw, sc, hit;
        nw = (cap_len >= 16) ? cap_len - 15 : 0;
        e.off = 0; e.score = 0; e.hit = 0;
        e.cycles = nw * (769 + 2 * n);
        for (int w = 0; w < nw; w++) begin
            model_eval(w, n, moff, mval, men, sc, hit);
            if (w == 0 || (hit == 1 && e.hit == 0) || (hit == e.hit && sc < e.score)) begin
                e.off = w; e.score = sc; e.hit = hit;
            end
        end
        cfg_cap_len = 7'(cap_len); cfg_dec_len = 6'(n); cfg_magic_off = 5'(moff);
        cfg_magic = mval; cfg_magic_en = men;
        sbq.push_back(e);
        last_e  = e;
        pending = 1;
        start   = 1'b1;
        t_start = $time;
        @(negedge clk);
        start = 1'b0;
        if (stray_start) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (pending == 0);
        repeat (3) @(negedge clk);
        chk(int'(best_offset) == e.off, "R9", "offset held after done", int'(best_offset), e.off);
        chk(int'(best_score) == e.score, "R9", "score held after done", int'(best_score), e.score);
    endtask

    // Monitor: pops expected items as done appears
    initial begin
        exp_t e;
        longint k;
        forever begin
            @(negedge clk);
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R7", "done without pending run", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    k = (($time - t_start) / PER) - 1;
                    chk(int'(best_offset) == e.off, "R3", "best offset", int'(best_offset), e.off);
                    chk(int'(best_score) == e.score, "R4", "best score", int'(best_score), e.score);
                    chk(int'(best_magic) == e.hit, "R5", "marker flag", int'(best_magic), e.hit);
                    chk(int'(k) == e.cycles, "R7", "done latency", int'(k), e.cycles);
                    chk(busy == 1'b0, "R7", "busy low with done", int'(busy), 0);
                    @(negedge clk);
                    chk(done == 1'b0, "R7", "done one cycle", int'(done), 0);
                    pending = 0;
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        logic [31:0] mv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(best_offset == '0, "R1", "offset after reset", int'(best_offset), 0);
        chk(best_score == '0, "R1", "score after reset", int'(best_score), 0);
        chk(best_magic == 1'b0, "R1", "marker after reset", int'(best_magic), 0);

        // R2: zero ciphertext exposes keystream; marker set to keystream bytes 4..7
        for (int a = 0; a < 24; a++) wr_cap(a, rnd8());
        for (int a = 0; a < CT_DEPTH; a++) wr_ct(a, 0);
        model_ks(0, 16);
        mv = {8'(ks_m[4]), 8'(ks_m[5]), 8'(ks_m[6]), 8'(ks_m[7])};
        run(16, 16, 4, mv, 1'b1, 1'b0);
        chk(best_magic == 1'b1, "R2", "keystream bytes 4..7 match", int'(best_magic), 1);
        run(16, 16, 4, mv ^ 32'h0000_0100, 1'b1, 1'b0);
        chk(best_magic == 1'b0, "R5", "altered marker misses", int'(best_magic), 0);

        // R5: marker beyond decrypt length never hits
        model_ks(0, 10);
        mv = {8'(ks_m[6]), 8'(ks_m[7]), 8'(ks_m[8]), 8'(ks_m[9])};
        run(16, 8, 6, mv, 1'b1, 1'b0);
        chk(best_magic == 1'b0, "R5", "marker past end", int'(best_magic), 0);

        // R3: planted key at offset 5 with low-entropy plaintext and marker
        for (int k = 0; k < 12; k++) pt_m[k] = 8'h41;
        pt_m[12] = 8'hC0; pt_m[13] = 8'hDE; pt_m[14] = 8'hF0; pt_m[15] = 8'h0D;
        plant(5, 16);
        run(24, 16, 12, 32'hC0DEF00D, 1'b1, 1'b0);
        chk(best_offset == 6'd5, "R3", "planted offset found", int'(best_offset), 5);
        chk(best_score == 6'd5, "R4", "planted distinct count", int'(best_score), 5);

        // R4 and R9: score-only ranking, stray start mid-run
        run(24, 16, 12, 32'hC0DEF00D, 1'b0, 1'b1);
        chk(best_offset == 6'd5, "R4", "score-only winner", int'(best_offset), 5);

        // R6: marker hit beats a lower score elsewhere
        for (int k = 0; k < 12; k++) pt_m[k] = (k * 17 + 3) & 255;
        pt_m[12] = 8'hCC; pt_m[13] = 8'hDD; pt_m[14] = 8'hEE; pt_m[15] = 8'hFF;
        plant(7, 16);
        run(24, 16, 12, 32'hCCDDEEFF, 1'b1, 1'b0);
        chk(best_offset == 6'd7, "R6", "marker outranks score", int'(best_offset), 7);

        // R6: period-4 buffer gives identical keys, earliest kept
        for (int a = 0; a < 24; a++) wr_cap(a, (a % 4) * 37 + 11);
        run(24, 12, 0, 32'h0, 1'b0, 1'b0);
        chk(best_offset < 6'd4, "R6", "tie keeps earliest", int'(best_offset), 0);

        // R8: buffer shorter than a key
        run(10, 16, 0, 32'h0, 1'b0, 1'b0);
        chk(best_score == '0 && best_magic == 1'b0, "R8", "empty search results", int'(best_score), 0);

        summary();
    end
endmodule